// File: doc/BRIEF.md
# Frequency-Locked Loop Digital Integrator

This block is the digital loop filter of a frequency-locked loop. On each reference tick a measured multiplication factor arrives: the number of oscillator cycles counted in one reference period. The block subtracts it from a requested factor and scales the signed difference by an arithmetic right shift set by a 4-bit gain. It adds the result into a 20-bit integrator. The upper 10 bits of the integrator drive the oscillator control code. The lower 10 bits are a fraction that, when dithering is on, lifts the code by one step on a share of ticks, so that the average code falls between integer steps.

In standalone mode the loop does not act. The code is a programmed fixed value, and the integrator tracks that value so that closed-loop operation begins from it when the mode switches. An open-loop hold freezes the integrator and the dither once an external lock indication is present. The integrator contents and the last measured factor are available for readback.

Top module: `fll_loop_filter`

## Requirements
- R1: After synchronous reset the integrator holds integer part 0x121 with fraction 0 (`integ_state` = 0x48400), the dither accumulator and step are clear, and `status_factor` is 0.
- R2: While `run_mode` is 0 (standalone), `osc_code` equals `fixed_code`, each clock loads the integrator with `fixed_code` in bits 19:10 and 0 in bits 9:0, and reference ticks do not change the integrator.
- R3: When `run_mode` goes from 0 to 1, closed-loop operation starts from integer part `fixed_code` and fraction 0.
- R4: In closed loop, each `ref_tick` adds (target − measured), taken as a signed value and arithmetically right-shifted by `loop_gain`, to the integrator (LSB = one fraction step). A shift of a negative error rounds toward minus infinity.
- R5: The integrator saturates at 0 and at 0xFFFFF instead of wrapping.
- R6: Without `ref_tick` the integrator does not change in closed loop.
- R7: When `open_loop_hold` and `locked` are both 1, a tick changes neither the integrator nor the dither state. Either input alone has no effect.
- R8: With `dither_en` set, each updating tick adds the pre-update fraction to a 10-bit accumulator. A carry out makes `osc_code` equal to the integer part plus one, saturating at 1023, until the next tick. With `dither_en` clear, the accumulator is cleared and `osc_code` equals the integer part.
- R9: `status_factor` takes `meas_factor` on every `ref_tick` in either mode and holds it otherwise.
- R10: `integ_state` shows the integer part in bits 19:10 and the fraction in bits 9:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference period, with `meas_factor` valid |
| meas_factor | input | 16 | Measured oscillator cycles per reference period |
| target_factor | input | 16 | Requested multiplication factor |
| loop_gain | input | 4 | Right-shift amount applied to the error |
| run_mode | input | 1 | 0 standalone, 1 closed loop |
| fixed_code | input | 10 | Oscillator code used in standalone mode |
| dither_en | input | 1 | Enables dithering of the code LSB |
| open_loop_hold | input | 1 | Freeze the loop when lock is present |
| locked | input | 1 | Lock indication from the lock detector |
| osc_code | output | 10 | Oscillator control code |
| status_factor | output | 16 | Last measured factor |
| integ_state | output | 20 | Integrator readback {integer, fraction} |

## Verification
A wrong integrator value appears on `integ_state` on the clock after the tick that caused it. It reaches `osc_code` in the same cycle, and in closed loop the code can differ from the integer part only by the one dither step. A wrong dither accumulator cannot be read directly. It shows up as a code bump on the wrong tick of a repeating pattern, so the bench checks every tick of a full dither period. A saturation or shift-sign error shows up as a large jump of the integer part on the first tick that reaches a limit.

// File: rtl/fll_lf_pkg.sv
// Shared definitions for the loop filter.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package fll_lf_pkg;

    typedef enum logic {
        MODE_STANDALONE = 1'b0,
        MODE_CLOSED     = 1'b1
    } loop_mode_e;

endpackage

// File: rtl/fll_err_scaler.sv
// Error scaler: signed (target - measured), arithmetic right shift by gain,
// sign-extended to the integrator adder width.
// Assumes: OUT_W > FACT_W + 1.
module fll_err_scaler #(
    parameter int FACT_W = 16,
    parameter int GAIN_W = 4,
    parameter int OUT_W  = 22
) (
    input  logic [FACT_W-1:0]       target,
    input  logic [FACT_W-1:0]       meas,
    input  logic [GAIN_W-1:0]       gain,
    output logic signed [OUT_W-1:0] step
);
    localparam int ERR_W = FACT_W + 1;

    logic signed [ERR_W-1:0] err;
    logic signed [ERR_W-1:0] shifted;

    // Signed difference and gain shift.
    always_comb begin
        err     = $signed({1'b0, target}) - $signed({1'b0, meas});
        shifted = err >>> gain;
    end

    assign step = {{(OUT_W - ERR_W){shifted[ERR_W-1]}}, shifted};
endmodule

// File: rtl/fll_integrator.sv
// Integrator register: loads a fixed integer part (fraction cleared) or adds a
// signed step with saturation at zero and all-ones.
// Assumes: STEP_W = ST_W + 2; the step magnitude is below 2**ST_W.
module fll_integrator #(
    parameter int INT_W      = 10,
    parameter int FRAC_W     = 10,
    parameter int RESET_CODE = 'h121,
    parameter int STEP_W     = INT_W + FRAC_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [INT_W-1:0]         load_val,
    input  logic                     upd,
    input  logic signed [STEP_W-1:0] step,
    output logic [INT_W+FRAC_W-1:0]  state
);
    localparam int ST_W = INT_W + FRAC_W;

    logic [ST_W-1:0]          state_q;
    logic [ST_W-1:0]          state_nxt;
    logic signed [STEP_W-1:0] sum;

    assign sum = $signed({2'b00, state_q}) + step;

    // Clamp the sum into [0, all-ones].
    always_comb begin
        if (sum[STEP_W-1])      state_nxt = '0;
        else if (sum[STEP_W-2]) state_nxt = '1;
        else                    state_nxt = sum[ST_W-1:0];
    end

    // State register: reset, standalone load, or tick update.
    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= {INT_W'(RESET_CODE), {FRAC_W{1'b0}}};
        else if (load) state_q <= {load_val, {FRAC_W{1'b0}}};
        else if (upd)  state_q <= state_nxt;
    end

    assign state = state_q;
endmodule

// File: rtl/fll_dither.sv
// First-order dither: accumulates the fraction on each advance; a carry out
// raises the code by one (saturating) until the next advance.
// Assumes: clear has priority over advance.
module fll_dither #(
    parameter int INT_W  = 10,
    parameter int FRAC_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              adv,
    input  logic [FRAC_W-1:0] frac,
    input  logic [INT_W-1:0]  int_part,
    output logic [INT_W-1:0]  code
);
    logic [FRAC_W-1:0] acc_q;
    logic              bump_q;
    logic [FRAC_W:0]   acc_sum;

    assign acc_sum = {1'b0, acc_q} + {1'b0, frac};

    // Accumulator and carry-bump register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q  <= '0;
            bump_q <= 1'b0;
        end else if (adv) begin
            acc_q  <= acc_sum[FRAC_W-1:0];
            bump_q <= acc_sum[FRAC_W];
        end
    end

    // Bumped code, held at the top value.
    always_comb begin
        if (bump_q && (int_part != {INT_W{1'b1}})) code = int_part + INT_W'(1);
        else                                     code = int_part;
    end
endmodule

// File: rtl/fll_loop_filter.sv
// Loop filter top: mode selection, freeze control, status capture, and the
// scaler / integrator / dither datapath.
// Assumes: ref_tick is a single-cycle pulse synchronous to clk.
module fll_loop_filter #(
    parameter int FACT_W     = 16,
    parameter int INT_W      = 10,
    parameter int FRAC_W     = 10,
    parameter int GAIN_W     = 4,
    parameter int RESET_CODE = 'h121
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_tick,
    input  logic [FACT_W-1:0]       meas_factor,
    input  logic [FACT_W-1:0]       target_factor,
    input  logic [GAIN_W-1:0]       loop_gain,
    input  logic                    run_mode,
    input  logic [INT_W-1:0]        fixed_code,
    input  logic                    dither_en,
    input  logic                    open_loop_hold,
    input  logic                    locked,
    output logic [INT_W-1:0]        osc_code,
    output logic [FACT_W-1:0]       status_factor,
    output logic [INT_W+FRAC_W-1:0] integ_state
);
    import fll_lf_pkg::*;

    localparam int ST_W   = INT_W + FRAC_W;
    localparam int STEP_W = ST_W + 2;

    loop_mode_e               mode;
    logic                     frozen;
    logic                     upd;
    logic signed [STEP_W-1:0] step;
    logic [INT_W-1:0]         dith_code;
    logic [FACT_W-1:0]        status_q;

    assign mode   = loop_mode_e'(run_mode);
    assign frozen = open_loop_hold && locked;
    assign upd    = (mode == MODE_CLOSED) && ref_tick && !frozen;

    fll_err_scaler #(.FACT_W(FACT_W), .GAIN_W(GAIN_W), .OUT_W(STEP_W)) u_scale (
        .target (target_factor),
        .meas   (meas_factor),
        .gain   (loop_gain),
        .step   (step)
    );

    fll_integrator #(.INT_W(INT_W), .FRAC_W(FRAC_W), .RESET_CODE(RESET_CODE),
                     .STEP_W(STEP_W)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mode == MODE_STANDALONE),
        .load_val (fixed_code),
        .upd      (upd),
        .step     (step),
        .state    (integ_state)
    );

    fll_dither #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dith (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!dither_en || (mode == MODE_STANDALONE)),
        .adv      (upd && dither_en),
        .frac     (integ_state[FRAC_W-1:0]),
        .int_part (integ_state[ST_W-1:FRAC_W]),
        .code     (dith_code)
    );

    // Capture the measured factor on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        status_q <= '0;
        else if (ref_tick) status_q <= meas_factor;
    end

    assign status_factor = status_q;
    assign osc_code      = (mode == MODE_STANDALONE) ? fixed_code : dith_code;
endmodule

// File: rtl/fll_loop_filter_chk.sv
// Property checker for fll_loop_filter, bound to every instance.
module fll_loop_filter_chk #(
    parameter int FACT_W = 16,
    parameter int INT_W  = 10,
    parameter int FRAC_W = 10,
    parameter int GAIN_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ref_tick,
    input logic [FACT_W-1:0]       meas_factor,
    input logic [FACT_W-1:0]       target_factor,
    input logic [GAIN_W-1:0]       loop_gain,
    input logic                    run_mode,
    input logic [INT_W-1:0]        fixed_code,
    input logic                    dither_en,
    input logic                    open_loop_hold,
    input logic                    locked,
    input logic [INT_W-1:0]        osc_code,
    input logic [FACT_W-1:0]       status_factor,
    input logic [INT_W+FRAC_W-1:0] integ_state
);
    localparam int ST_W = INT_W + FRAC_W;

    // R2: standalone loads the fixed code with a cleared fraction.
    a_r2_standalone_load: assert property (@(posedge clk) disable iff (!rst_n)
        !run_mode |=> integ_state == {$past(fixed_code), {FRAC_W{1'b0}}});

    // R6: no tick, no change in closed loop.
    a_r6_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode && !ref_tick) |=> $stable(integ_state));

    // R7: hold plus lock freezes the integrator.
    a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode && open_loop_hold && locked) |=> $stable(integ_state));

    // R8: code stays within one step above the integer part.
    a_r8_code_window: assert property (@(posedge clk) disable iff (!rst_n)
        run_mode |-> (({1'b0, osc_code} == {1'b0, integ_state[ST_W-1:FRAC_W]}) ||
                      ({1'b0, osc_code} == {1'b0, integ_state[ST_W-1:FRAC_W]} + 1'b1)));

    // R8: dither off gives the plain integer part.
    a_r8_dither_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!dither_en || !run_mode) |=> (!run_mode || osc_code == integ_state[ST_W-1:FRAC_W]));

    // R9: tick captures the measured factor.
    a_r9_status_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> status_factor == $past(meas_factor));

    // R9: no tick keeps the status.
    a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(status_factor));
endmodule

bind fll_loop_filter fll_loop_filter_chk #(
    .FACT_W(FACT_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .GAIN_W(GAIN_W)
) u_chk (.*);

// File: tb/tb_fll_loop_filter.sv
`timescale 1ns/1ps
module tb_fll_loop_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [15:0] meas_factor = 16'h0;
    logic [15:0] target_factor = 16'h5F5;
    logic [3:0]  loop_gain = 4'd9;
    logic        run_mode = 1'b1;
    logic [9:0]  fixed_code = 10'h2A5;
    logic        dither_en = 1'b0;
    logic        open_loop_hold = 1'b0;
    logic        locked = 1'b0;
    logic [9:0]  osc_code;
    logic [15:0] status_factor;
    logic [19:0] integ_state;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int m_state, m_acc, m_bump, m_status;

    always #2 clk = ~clk;

    fll_loop_filter dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .meas_factor(meas_factor),
        .target_factor(target_factor), .loop_gain(loop_gain), .run_mode(run_mode),
        .fixed_code(fixed_code), .dither_en(dither_en), .open_loop_hold(open_loop_hold),
        .locked(locked), .osc_code(osc_code), .status_factor(status_factor),
        .integ_state(integ_state)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_code();
        int c;
        if (!run_mode) return int'(fixed_code);
        c = (m_state >> 10) + m_bump;
        return (c > 1023) ? 1023 : c;
    endfunction

    // Requirement-level model for one clock edge with the current inputs.
    task automatic model_step(bit tick, int meas);
        int e, s;
        if (tick) m_status = meas;
        if (!run_mode) begin
            m_state = int'(fixed_code) << 10; m_acc = 0; m_bump = 0;
        end else begin
            if (!dither_en) begin m_acc = 0; m_bump = 0; end
            if (tick && !(open_loop_hold && locked)) begin
                if (dither_en) begin
                    s = m_acc + (m_state & 1023);
                    m_bump = (s >= 1024) ? 1 : 0;
                    m_acc = s & 1023;
                end
                e = (int'(target_factor) - meas) >>> loop_gain;
                m_state = m_state + e;
                if (m_state < 0) m_state = 0;
                if (m_state > 'hFFFFF) m_state = 'hFFFFF;
            end
        end
    endtask

    // One clock from a negedge to the next, optionally with a tick.
    task automatic cycle(bit tick, int meas);
        ref_tick = tick;
        meas_factor = 16'(meas);
        model_step(tick, meas);
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic check_all(string tag);
        check({tag, " code"}, int'(osc_code), exp_code());
        check({tag, " state"}, int'(integ_state), m_state);
        check({tag, " status"}, int'(status_factor), m_status);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_state = 'h121 << 10; m_acc = 0; m_bump = 0; m_status = 0;
        check("R1 reset state", int'(integ_state), 'h48400);
        check("R1 reset code", int'(osc_code), 'h121);
        check("R1 reset status", int'(status_factor), 0);
    endtask

    task automatic t_standalone();
        run_mode = 1'b0; fixed_code = 10'h2A5;
        cycle(0, 0);
        check_all("R2 standalone load");
        cycle(1, 'h1234);
        check("R2 tick ignored", int'(integ_state), 'h2A5 << 10);
        check("R2 code fixed", int'(osc_code), 'h2A5);
        check("R9 status standalone", int'(status_factor), 'h1234);
    endtask

    task automatic t_switch();
        run_mode = 1'b1;
        cycle(0, 'h1234);
        check("R3 integer after switch", int'(integ_state[19:10]), 'h2A5);
        check("R10 fraction after switch", int'(integ_state[9:0]), 0);
        check_all("R3 switch");
    endtask

    task automatic t_step();
        loop_gain = 4'd9;
        cycle(1, 'h1F5);
        check("R4 gain 9 positive", int'(integ_state), 'hA9402);
        loop_gain = 4'd0;
        cycle(1, 'h5F8);
        check("R4 gain 0 negative", int'(integ_state), 'hA93FF);
        loop_gain = 4'd4;
        cycle(1, 'h5F6);
        check("R4 arithmetic shift of -1", int'(integ_state), 'hA93FE);
        cycle(1, 'h5F4);
        check("R4 shift of +1 to zero", int'(integ_state), 'hA93FE);
        check("R10 fraction field", int'(integ_state[9:0]), 'h3FE);
        check_all("R4 step");
    endtask

    task automatic t_notick();
        loop_gain = 4'd0;
        cycle(0, 'h0010);
        cycle(0, 'h0020);
        check("R6 no tick stable", int'(integ_state), 'hA93FE);
        check("R9 status held", int'(status_factor), 'h5F4);
    endtask

    task automatic t_sat();
        run_mode = 1'b0; fixed_code = 10'h000;
        cycle(0, 0);
        run_mode = 1'b1; loop_gain = 4'd0;
        cycle(1, 'h5FA);
        check("R5 floor at zero", int'(integ_state), 0);
        run_mode = 1'b0; fixed_code = 10'h3FF;
        cycle(0, 0);
        run_mode = 1'b1; target_factor = 16'hFFFF;
        cycle(1, 0);
        check("R5 ceiling", int'(integ_state), 'hFFFFF);
        check("R5 ceiling code", int'(osc_code), 'h3FF);
        dither_en = 1'b1;
        cycle(1, 'hFFFF);
        cycle(1, 'hFFFF);
        check("R8 bump saturates at 1023", int'(osc_code), 'h3FF);
        check_all("R8 saturated dither");
        dither_en = 1'b0;
        target_factor = 16'h5F5;
        cycle(0, 0);
    endtask

    task automatic t_dither();
        run_mode = 1'b0; fixed_code = 10'h100;
        cycle(0, 0);
        run_mode = 1'b1; loop_gain = 4'd0;
        cycle(1, 'h4F5);
        check("R4 load quarter fraction", int'(integ_state), 'h40100);
        dither_en = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            cycle(1, 'h5F5);
            check($sformatf("R8 dither tick %0d", k), int'(osc_code),
                  (k % 4 == 0) ? 'h101 : 'h100);
        end
        cycle(1, 'h5F5);
        check_all("R8 dither model");
        dither_en = 1'b0;
        cycle(0, 'h5F5);
        check("R8 dither off code", int'(osc_code), 'h100);
    endtask

    task automatic t_hold();
        loop_gain = 4'd0;
        open_loop_hold = 1'b1; locked = 1'b1;
        cycle(1, 'h5F0);
        check("R7 frozen by hold and lock", int'(integ_state), 'h40100);
        locked = 1'b0;
        cycle(1, 'h5F0);
        check("R7 hold alone no effect", int'(integ_state), 'h40105);
        open_loop_hold = 1'b0; locked = 1'b1;
        cycle(1, 'h5F0);
        check("R7 lock alone no effect", int'(integ_state), 'h4010A);
        locked = 1'b0;
        check_all("R7 hold");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_standalone();
        t_switch();
        t_step();
        t_notick();
        t_sat();
        t_dither();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule